// File: doc/BRIEF.md
# Multi-Mode 16-bit Timer Channel

This block is a single timer channel built around a 16-bit up-counter and two general registers, A and B. Depending on its control fields, the same two registers act as compare values that drive two output pins, as latches that take a snapshot of the counter when an edge arrives on one of two input pins, or as the set and reset points of a pulse-width waveform. The counter advances on a tick taken from a prescaled version of the block clock or from falling edges of an external clock input. The counter can be restarted on a compare match or on a capture edge, which gives periodic counting and controlled duty cycles, including 0% and 100%.

Software reaches the channel through a simple register port: a write strobe with address and data, and a combinational read path selected by its own address. Three sticky event flags (wrap, event on A, event on B) are cleared by writing ones. Each flag can be routed to the single interrupt output through an enable mask.

Top module: `tmr16_channel`

## Requirements
- R1: After a synchronous reset the counter reads 0, both general registers read 0xFFFF, the control, output-action, enable and flag registers read 0, both output pins are 0 and `irq` is 0.
- R2: Register map by `wr_addr`/`rd_addr`: 0 control, 1 output actions, 2 interrupt enables, 3 flags, 4 counter, 5 register A, 6 register B. In the control word, bit 0 is run and bits 3:1 are the tick select. The counter advances only while run is 1. Tick selects 0, 1, 2 and 3 advance it once every 2, 4, 16 and 64 clocks. The prescaler restarts from zero while run is 0, so after the clock edge that sets run the counter holds floor(c/N) c edges later.
- R3: Tick selects 4 to 7 advance the counter once per falling edge of `ext_clk_in`, no later than the third rising clock edge after that edge. Rising edges of `ext_clk_in` do not advance the counter.
- R4: On a tick with the counter at 0xFFFF and no clear pending, the counter becomes 0 and flag bit 0 is set. `irq` is high while any flag bit is 1 with the same bit set in the enable register.
- R5: On a tick with the counter equal to register A (B) while that register is not in capture mode, flag bit 1 (2) is set. The A (B) output pin takes the action in output-action bits 1:0 (3:2), where 0 means keep, 1 means drive 0, 2 means drive 1 and 3 means toggle.
- R6: Control bits 5:4 choose the clear source: 1 clears the counter on a match or a capture of A, 2 clears it on B, and 0 or 3 disables clearing. With clear on a match of value G the counter runs 0..G, so it has a period of G+1 ticks.
- R7: Control bits 7 and 8 put A and B in capture mode, and bits 9 and 10 choose the falling edge (1) or the rising edge (0) of `pin_a_in` and `pin_b_in`. The counter value is copied into the register and the flag bit is set at the third rising clock edge after the pin changes. This happens whether or not run is set. The edge that was not selected has no effect.
- R8: With control bit 6 set (PWM), only `pin_a_out` is driven: a match with A sets it to 1 and a match with B sets it to 0, and B wins when both match on the same tick. B as clear source with A above B holds the pin at 0 (0% duty). A as clear source with B above A holds it at 1 (100% duty).
- R9: Flags are sticky. Writing a 1 to a flag bit clears it, but an event on the same edge keeps the flag set.
- R10: When a match and a wrap fall on the same tick, both flags are set and the pin action of the match is applied.
- R11: A write to the counter takes priority over counting and clearing, and counting continues from the written value. Every written register reads back through `rd_data`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write address |
| wr_data | input | 16 | Register write data |
| rd_addr | input | 3 | Register read address |
| rd_data | output | 16 | Read data for `rd_addr` |
| ext_clk_in | input | 1 | External count clock (falling edge counts) |
| pin_a_in | input | 1 | Capture input for register A |
| pin_b_in | input | 1 | Capture input for register B |
| pin_a_out | output | 1 | Compare / PWM output A |
| pin_b_out | output | 1 | Compare output B |
| irq | output | 1 | Interrupt request, any enabled flag |

## Verification
The counter is checked on every clock across all four prescale ratios and against a slow external clock. Checking every clock shows both the count rate and the phase of the first tick. A run that starts just below the wrap value, with A and B placed at 0xFFF8 and 0xFFFF, separates the wrap flag from the match flags and shows the case where a match and a wrap share a tick. Clear-on-match sweeps over several periods on A and on B compare the counter and the toggle pin with k mod (G+1), and a flag clear timed exactly on a match edge shows the set-wins rule. Capture is tried with rising and falling selects and with the edge that was not selected. PWM is tried with a normal duty and with the 0% and 100% register settings.

// File: rtl/tmr16_pkg.sv
package tmr16_pkg;

    typedef enum logic [2:0] {
        A_CTRL   = 3'd0,
        A_OUTCFG = 3'd1,
        A_IEN    = 3'd2,
        A_STAT   = 3'd3,
        A_CNT    = 3'd4,
        A_GRA    = 3'd5,
        A_GRB    = 3'd6
    } reg_addr_e;

    typedef enum logic [1:0] {
        ACT_KEEP   = 2'd0,
        ACT_LOW    = 2'd1,
        ACT_HIGH   = 2'd2,
        ACT_TOGGLE = 2'd3
    } pin_act_e;

    typedef enum logic [1:0] {
        CLR_OFF  = 2'd0,
        CLR_A    = 2'd1,
        CLR_B    = 2'd2,
        CLR_OFF2 = 2'd3
    } clr_src_e;

    typedef struct packed {
        logic     cap_b_fall;
        logic     cap_a_fall;
        logic     cap_b_en;
        logic     cap_a_en;
        logic     pwm_en;
        clr_src_e clr;
        logic [2:0] tick_sel;
        logic     run;
    } ctrl_t;

    localparam int CTRL_W = $bits(ctrl_t);
    localparam int FLG_W  = 3;
    localparam int FLG_OVF = 0;
    localparam int FLG_A   = 1;
    localparam int FLG_B   = 2;

    function automatic logic apply_act(pin_act_e act, logic cur);
        case (act)
            ACT_LOW:    return 1'b0;
            ACT_HIGH:   return 1'b1;
            ACT_TOGGLE: return ~cur;
            default:    return cur;
        endcase
    endfunction

    function automatic int div_shift(logic [1:0] sel);
        case (sel)
            2'd0:    return 1;
            2'd1:    return 2;
            2'd2:    return 4;
            default: return 6;
        endcase
    endfunction

endpackage

// File: rtl/tmr16_edge_sync.sv
module tmr16_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic rise,
    output logic fall
);
    localparam int TOP = STAGES - 1;

    logic [STAGES-1:0] chain_q;
    logic              prev_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            chain_q <= '0;
            prev_q  <= 1'b0;
        end else begin
            chain_q <= {chain_q[STAGES-2:0], din};
            prev_q  <= chain_q[TOP];
        end
    end

    assign rise = chain_q[TOP] & ~prev_q;
    assign fall = ~chain_q[TOP] & prev_q;
endmodule

// File: rtl/tmr16_tick_gen.sv
module tmr16_tick_gen
    import tmr16_pkg::*;
#(
    parameter int PRE_W = 6
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       run,
    input  logic [2:0] tick_sel,
    input  logic       ext_fall,
    output logic       tick
);
    logic [PRE_W-1:0] pre_q;
    logic [PRE_W-1:0] mask;

    always_comb begin
        mask = ~({PRE_W{1'b1}} << div_shift(tick_sel[1:0]));
    end

    always_ff @(posedge clk) begin
        if (rst || !run) pre_q <= '0;
        else             pre_q <= pre_q + 1'b1;
    end

    assign tick = run & (tick_sel[2] ? ext_fall : ((pre_q & mask) == mask));
endmodule

// File: rtl/tmr16_pin_ctl.sv
module tmr16_pin_ctl
    import tmr16_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     pwm_en,
    input  pin_act_e act_a,
    input  pin_act_e act_b,
    input  logic     match_a,
    input  logic     match_b,
    output logic     pin_a,
    output logic     pin_b
);
    logic nxt_a, nxt_b;

    always_comb begin
        nxt_a = pin_a;
        nxt_b = pin_b;
        if (pwm_en) begin
            if (match_a) nxt_a = 1'b1;
            if (match_b) nxt_a = 1'b0;
        end else begin
            if (match_a) nxt_a = apply_act(act_a, pin_a);
            if (match_b) nxt_b = apply_act(act_b, pin_b);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pin_a <= 1'b0;
            pin_b <= 1'b0;
        end else begin
            pin_a <= nxt_a;
            pin_b <= nxt_b;
        end
    end
endmodule

// File: rtl/tmr16_channel.sv
module tmr16_channel
    import tmr16_pkg::*;
#(
    parameter int CNT_W       = 16,
    parameter int SYNC_STAGES = 2,
    parameter int PRE_W       = 6
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [2:0]       wr_addr,
    input  logic [CNT_W-1:0] wr_data,
    input  logic [2:0]       rd_addr,
    output logic [CNT_W-1:0] rd_data,
    input  logic             ext_clk_in,
    input  logic             pin_a_in,
    input  logic             pin_b_in,
    output logic             pin_a_out,
    output logic             pin_b_out,
    output logic             irq
);
    localparam logic [CNT_W-1:0] CNT_TOP = '1;

    ctrl_t              ctrl_q;
    pin_act_e           act_a_q, act_b_q;
    logic [FLG_W-1:0]   ien_q, flags_q, flag_set, flag_clr;
    logic [CNT_W-1:0]   cnt_q, gra_q, grb_q;

    logic wr_ctrl, wr_out, wr_ien, wr_stat, wr_cnt, wr_gra, wr_grb;
    logic tick, ext_fall, ext_rise_unused_sink;
    logic a_rise, a_fall, b_rise, b_fall;
    logic cap_a, cap_b, match_a, match_b, clr_hit, wrap;

    assign wr_ctrl = wr_en && (wr_addr == A_CTRL);
    assign wr_out  = wr_en && (wr_addr == A_OUTCFG);
    assign wr_ien  = wr_en && (wr_addr == A_IEN);
    assign wr_stat = wr_en && (wr_addr == A_STAT);
    assign wr_cnt  = wr_en && (wr_addr == A_CNT);
    assign wr_gra  = wr_en && (wr_addr == A_GRA);
    assign wr_grb  = wr_en && (wr_addr == A_GRB);

    // input conditioning: external clock and both capture pins
    tmr16_edge_sync #(.STAGES(SYNC_STAGES)) u_sync_ext (
        .clk(clk), .rst(rst), .din(ext_clk_in),
        .rise(ext_rise_unused_sink), .fall(ext_fall)
    );
    tmr16_edge_sync #(.STAGES(SYNC_STAGES)) u_sync_a (
        .clk(clk), .rst(rst), .din(pin_a_in), .rise(a_rise), .fall(a_fall)
    );
    tmr16_edge_sync #(.STAGES(SYNC_STAGES)) u_sync_b (
        .clk(clk), .rst(rst), .din(pin_b_in), .rise(b_rise), .fall(b_fall)
    );

    tmr16_tick_gen #(.PRE_W(PRE_W)) u_tick (
        .clk(clk), .rst(rst), .run(ctrl_q.run), .tick_sel(ctrl_q.tick_sel),
        .ext_fall(ext_fall), .tick(tick)
    );

    // events
    assign cap_a   = ctrl_q.cap_a_en & (ctrl_q.cap_a_fall ? a_fall : a_rise);
    assign cap_b   = ctrl_q.cap_b_en & (ctrl_q.cap_b_fall ? b_fall : b_rise);
    assign match_a = tick & ~ctrl_q.cap_a_en & (cnt_q == gra_q);
    assign match_b = tick & ~ctrl_q.cap_b_en & (cnt_q == grb_q);
    assign clr_hit = ((ctrl_q.clr == CLR_A) & (match_a | cap_a))
                   | ((ctrl_q.clr == CLR_B) & (match_b | cap_b));
    assign wrap    = tick & (cnt_q == CNT_TOP) & ~clr_hit & ~wr_cnt;

    assign flag_set = {match_b | cap_b, match_a | cap_a, wrap};
    assign flag_clr = wr_stat ? wr_data[FLG_W-1:0] : '0;

    // configuration registers
    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q  <= '0;
            act_a_q <= ACT_KEEP;
            act_b_q <= ACT_KEEP;
            ien_q   <= '0;
        end else begin
            if (wr_ctrl) ctrl_q <= ctrl_t'(wr_data[CTRL_W-1:0]);
            if (wr_out) begin
                act_a_q <= pin_act_e'(wr_data[1:0]);
                act_b_q <= pin_act_e'(wr_data[3:2]);
            end
            if (wr_ien) ien_q <= wr_data[FLG_W-1:0];
        end
    end

    // counter, general registers, flags
    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q   <= '0;
            gra_q   <= '1;
            grb_q   <= '1;
            flags_q <= '0;
        end else begin
            if (wr_cnt)       cnt_q <= wr_data;
            else if (clr_hit) cnt_q <= '0;
            else if (tick)    cnt_q <= cnt_q + 1'b1;

            if (wr_gra)     gra_q <= wr_data;
            else if (cap_a) gra_q <= cnt_q;

            if (wr_grb)     grb_q <= wr_data;
            else if (cap_b) grb_q <= cnt_q;

            flags_q <= (flags_q & ~flag_clr) | flag_set;
        end
    end

    tmr16_pin_ctl u_pins (
        .clk(clk), .rst(rst), .pwm_en(ctrl_q.pwm_en),
        .act_a(act_a_q), .act_b(act_b_q),
        .match_a(match_a), .match_b(match_b),
        .pin_a(pin_a_out), .pin_b(pin_b_out)
    );

    assign irq = |(flags_q & ien_q);

    always_comb begin
        case (reg_addr_e'(rd_addr))
            A_CTRL:   rd_data = CNT_W'(ctrl_q);
            A_OUTCFG: rd_data = CNT_W'({act_b_q, act_a_q});
            A_IEN:    rd_data = CNT_W'(ien_q);
            A_STAT:   rd_data = CNT_W'(flags_q);
            A_CNT:    rd_data = cnt_q;
            A_GRA:    rd_data = gra_q;
            A_GRB:    rd_data = grb_q;
            default:  rd_data = '0;
        endcase
    end
endmodule

// File: rtl/tmr16_channel_chk.sv
module tmr16_channel_chk #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst,
    input logic             run,
    input logic             tick,
    input logic [1:0]       clr_src,
    input logic             pwm_en,
    input logic             cap_any,
    input logic             match_a,
    input logic             match_b,
    input logic             wr_en,
    input logic [2:0]       wr_addr,
    input logic [CNT_W-1:0] wr_data,
    input logic [CNT_W-1:0] cnt,
    input logic [2:0]       flags,
    input logic             pin_a_out
);
    logic wr_cnt, wr_stat;
    assign wr_cnt  = wr_en && (wr_addr == 3'd4);
    assign wr_stat = wr_en && (wr_addr == 3'd3);

    assert_stopped_hold_R2: assert property (@(posedge clk) disable iff (rst)
        (!run && !wr_cnt && !cap_any) |=> $stable(cnt));

    assert_step_one_R2: assert property (@(posedge clk) disable iff (rst)
        (run && !wr_cnt) |=> ((cnt == CNT_W'($past(cnt) + 1'b1)) || (cnt == $past(cnt)) || (cnt == '0)));

    assert_wrap_flag_R4: assert property (@(posedge clk) disable iff (rst)
        (tick && (cnt == '1) && !wr_cnt && !cap_any && (clr_src == 2'd0 || clr_src == 2'd3))
        |=> ((cnt == '0) && flags[0]));

    assert_sticky_ovf_R9: assert property (@(posedge clk) disable iff (rst)
        (flags[0] && !(wr_stat && wr_data[0])) |=> flags[0]);

    assert_sticky_a_R9: assert property (@(posedge clk) disable iff (rst)
        (flags[1] && !(wr_stat && wr_data[1])) |=> flags[1]);

    assert_sticky_b_R9: assert property (@(posedge clk) disable iff (rst)
        (flags[2] && !(wr_stat && wr_data[2])) |=> flags[2]);

    assert_pwm_reset_R8: assert property (@(posedge clk) disable iff (rst)
        (pwm_en && match_b) |=> !pin_a_out);

    assert_pwm_set_R8: assert property (@(posedge clk) disable iff (rst)
        (pwm_en && match_a && !match_b) |=> pin_a_out);
endmodule

bind tmr16_channel tmr16_channel_chk #(.CNT_W(CNT_W)) u_chk (
    .clk(clk), .rst(rst), .run(ctrl_q.run), .tick(tick), .clr_src(ctrl_q.clr),
    .pwm_en(ctrl_q.pwm_en), .cap_any(cap_a | cap_b), .match_a(match_a),
    .match_b(match_b), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .cnt(cnt_q), .flags(flags_q), .pin_a_out(pin_a_out)
);

// File: tb/tmr16_channel_bench.sv
`timescale 1ns/1ps
module tmr16_channel_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_addr = '0;
    logic [15:0] wr_data = '0;
    logic [2:0]  rd_addr = '0;
    logic [15:0] rd_data;
    logic        ext_clk_in = 1'b0, pin_a_in = 1'b0, pin_b_in = 1'b0;
    logic        pin_a_out, pin_b_out, irq;

    int n_checks = 0;
    int n_fails  = 0;

    always #2.5 clk = ~clk;

    tmr16_channel u_tmr16_channel (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data), .ext_clk_in(ext_clk_in),
        .pin_a_in(pin_a_in), .pin_b_in(pin_b_in), .pin_a_out(pin_a_out),
        .pin_b_out(pin_b_out), .irq(irq)
    );

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: actual 0x%04h expected 0x%04h at %0t", req, act, exp, $time);
        end
    endtask

    // called at a negedge; returns at the negedge after the write edge
    task automatic wr(input logic [2:0] a, input logic [15:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(posedge clk);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [15:0] d);
        rd_addr = a;
        #0.5;
        d = rd_data;
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    function automatic logic [15:0] mkctrl(input bit run, input int sel, input int clr,
                                           input bit pwm, input bit cae, input bit cbe,
                                           input bit caf, input bit cbf);
        return {5'b0, cbf, caf, cbe, cae, pwm, 2'(clr), 3'(sel), run};
    endfunction

    task automatic restart(input logic [15:0] ctrl_run);
        wr(3'd0, ctrl_run & 16'hFFFE);
        wr(3'd4, 16'h0000);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fails++;
        $display("FAIL watchdog: actual running expected done");
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end

    initial begin
        logic [15:0] v;
        logic        p0, pb0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        rd(3'd4, v); chk("R1 cnt", v, 16'h0000);
        rd(3'd5, v); chk("R1 gra", v, 16'hFFFF);
        rd(3'd6, v); chk("R1 grb", v, 16'hFFFF);
        rd(3'd0, v); chk("R1 ctrl", v, 16'h0000);
        rd(3'd3, v); chk("R1 stat", v, 16'h0000);
        chk("R1 pins/irq", {13'b0, pin_a_out, pin_b_out, irq}, 16'h0000);

        // R2 prescaler sweep
        for (int s = 0; s < 4; s++) begin
            int n;
            n = (s == 0) ? 2 : (s == 1) ? 4 : (s == 2) ? 16 : 64;
            restart(mkctrl(1, s, 0, 0, 0, 0, 0, 0));
            wr(3'd0, mkctrl(1, s, 0, 0, 0, 0, 0, 0));
            for (int c = 1; c <= 140; c++) begin
                step();
                rd(3'd4, v); chk("R2 prescale count", v, 16'(c / n));
            end
        end
        // R2 hold when stopped
        wr(3'd0, mkctrl(0, 0, 0, 0, 0, 0, 0, 0));
        rd(3'd4, v);
        begin
            logic [15:0] held;
            held = v;
            repeat (10) step();
            rd(3'd4, v); chk("R2 stopped hold", v, held);
        end

        // R11 counter write while running, read-back
        wr(3'd0, mkctrl(1, 0, 0, 0, 0, 0, 0, 0));
        repeat (5) step();
        wr(3'd4, 16'h0100);
        rd(3'd4, v); chk("R11 cnt write wins", v, 16'h0100);
        step(); step();
        rd(3'd4, v); chk("R11 count resumes", v, 16'h0101);
        rd(3'd0, v); chk("R11 ctrl readback", v, mkctrl(1, 0, 0, 0, 0, 0, 0, 0));

        // R3 external clock
        restart(mkctrl(1, 4, 0, 0, 0, 0, 0, 0));
        wr(3'd0, mkctrl(1, 4, 0, 0, 0, 0, 0, 0));
        for (int i = 1; i <= 10; i++) begin
            ext_clk_in = 1'b1;
            repeat (4) step();
            rd(3'd4, v); chk("R3 rising ignored", v, 16'(i - 1));
            ext_clk_in = 1'b0;
            repeat (4) step();
            rd(3'd4, v); chk("R3 falling counts", v, 16'(i));
        end

        // R4 wrap, R5 drive-high actions, R10 simultaneous match and wrap
        wr(3'd0, mkctrl(0, 0, 0, 0, 0, 0, 0, 0));
        wr(3'd3, 16'h0007);
        wr(3'd1, 16'h000A);
        wr(3'd2, 16'h0001);
        wr(3'd5, 16'hFFF8);
        wr(3'd6, 16'hFFFF);
        wr(3'd4, 16'hFFF0);
        rd(3'd1, v); chk("R11 outcfg readback", v, 16'h000A);
        rd(3'd2, v); chk("R11 ien readback", v, 16'h0001);
        wr(3'd0, mkctrl(1, 0, 0, 0, 0, 0, 0, 0));
        for (int c = 1; c <= 40; c++) begin
            int k;
            step();
            k = c / 2;
            rd(3'd4, v); chk("R4 count through wrap", v, 16'(32'hFFF0 + k));
            rd(3'd3, v); chk("R10 flags", v, {13'b0, k >= 16, k >= 9, k >= 16});
            chk("R5 pin drive1", {14'b0, pin_a_out, pin_b_out}, {14'b0, k >= 9, k >= 16});
            chk("R4 irq", {15'b0, irq}, {15'b0, k >= 16});
        end

        // R9 write-one-to-clear
        wr(3'd3, 16'h0001);
        rd(3'd3, v); chk("R9 clear ovf only", v, 16'h0006);
        chk("R9 irq drops", {15'b0, irq}, 16'h0000);

        // R5 toggle / drive0, R6 clear source sweep
        wr(3'd1, 16'h0007);
        wr(3'd2, 16'h0000);
        for (int t = 0; t < 4; t++) begin
            int g; bit on_b;
            on_b = (t == 3);
            g = (t == 0) ? 1 : (t == 1) ? 3 : (t == 2) ? 6 : 4;
            restart(mkctrl(1, 0, on_b ? 2 : 1, 0, 0, 0, 0, 0));
            wr(3'd3, 16'h0007);
            wr(3'd5, on_b ? 16'hFFFF : 16'(g));
            wr(3'd6, on_b ? 16'(g) : 16'h0000);
            p0 = pin_a_out; pb0 = pin_b_out;
            wr(3'd0, mkctrl(1, 0, on_b ? 2 : 1, 0, 0, 0, 0, 0));
            for (int c = 1; c <= 60; c++) begin
                int k, m;
                step();
                k = c / 2;
                m = k / (g + 1);
                rd(3'd4, v); chk("R6 periodic count", v, 16'(k % (g + 1)));
                if (!on_b) begin
                    chk("R5 toggle pin a", {15'b0, pin_a_out}, {15'b0, p0 ^ m[0]});
                    chk("R5 drive0 pin b", {15'b0, pin_b_out}, {15'b0, (k >= 1) ? 1'b0 : pb0});
                    rd(3'd3, v); chk("R5 flag a", {15'b0, v[1]}, {15'b0, m >= 1});
                end else begin
                    rd(3'd3, v); chk("R6 flag b", {15'b0, v[2]}, {15'b0, m >= 1});
                end
            end
        end

        // R9 set wins over clear on the same edge
        restart(mkctrl(1, 0, 1, 0, 0, 0, 0, 0));
        wr(3'd5, 16'h0001);
        wr(3'd3, 16'h0007);
        wr(3'd0, mkctrl(1, 0, 1, 0, 0, 0, 0, 0));
        repeat (7) step();
        wr(3'd3, 16'h0002);
        rd(3'd3, v); chk("R9 set wins", {15'b0, v[1]}, 16'h0001);
        step();
        wr(3'd3, 16'h0002);
        rd(3'd3, v); chk("R9 clear takes", {15'b0, v[1]}, 16'h0000);

        // R7 capture
        wr(3'd0, mkctrl(0, 0, 1, 0, 1, 1, 0, 1));
        wr(3'd6, 16'h5555);
        wr(3'd4, 16'h1234);
        wr(3'd3, 16'h0007);
        pin_a_in = 1'b1;
        step(); step();
        rd(3'd5, v); chk("R7 not yet captured", v, 16'h0001);
        step();
        rd(3'd5, v); chk("R7 capture a", v, 16'h1234);
        rd(3'd3, v); chk("R7 flag a", v, 16'h0002);
        rd(3'd4, v); chk("R7 clear on capture", v, 16'h0000);
        wr(3'd4, 16'h0BEE);
        pin_b_in = 1'b1;
        repeat (4) step();
        rd(3'd6, v); chk("R7 rising ignored on b", v, 16'h5555);
        rd(3'd3, v); chk("R7 no flag b", v, 16'h0002);
        pin_b_in = 1'b0;
        repeat (3) step();
        rd(3'd6, v); chk("R7 capture b falling", v, 16'h0BEE);
        rd(3'd3, v); chk("R7 flag b", v, 16'h0006);
        rd(3'd4, v); chk("R7 no clear from b", v, 16'h0BEE);
        wr(3'd4, 16'h0777);
        pin_a_in = 1'b0;
        repeat (4) step();
        rd(3'd5, v); chk("R7 falling ignored on a", v, 16'h1234);

        // R8 PWM: normal, 100%, 0%
        for (int t = 0; t < 3; t++) begin
            int clr, ga, gb, per;
            clr = (t == 1) ? 1 : 2;
            ga  = (t == 0) ? 2 : (t == 1) ? 3 : 10;
            gb  = (t == 0) ? 5 : (t == 1) ? 10 : 3;
            per = (t == 0) ? 6 : 4;
            restart(mkctrl(1, 0, clr, 1, 0, 0, 0, 0));
            wr(3'd5, 16'(ga));
            wr(3'd6, 16'(gb));
            p0 = pin_a_out; pb0 = pin_b_out;
            wr(3'd0, mkctrl(1, 0, clr, 1, 0, 0, 0, 0));
            for (int c = 1; c <= 72; c++) begin
                int k; logic e;
                step();
                k = c / 2;
                if (t == 0)      e = (k < 3) ? p0 : ((k % 6) >= 3);
                else if (t == 1) e = (k >= 4) ? 1'b1 : p0;
                else             e = (k >= 4) ? 1'b0 : p0;
                rd(3'd4, v); chk("R8 pwm count", v, 16'(k % per));
                chk("R8 pwm pin a", {15'b0, pin_a_out}, {15'b0, e});
                chk("R8 pin b held", {15'b0, pin_b_out}, {15'b0, pb0});
            end
        end

        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end
endmodule